// File: doc/BRIEF.md
# Resistor-Capacitor PUF Challenge Sequencer

This block runs the digital side of a physically unclonable function built from an external resistor-capacitor network. On a start request it captures a 32-bit challenge and its timing setup. It then holds the selected drive line low to discharge the network, and plays the challenge out on that line one bit per bit-delay period, least significant bit first. When the final bit's period has expired, it requests one conversion from an external ADC. When the ADC signals that the conversion is complete, the block picks one mid-order bit out of the 12-bit sample as that run's vote.

The bit-delay period is counted in clock cycles. It is either one common value (fixed mode) or a base value plus a per-device calibration value (variable mode). Variable mode makes the timing, and so the response, specific to each device. The same challenge can be repeated an odd number of times. The final response is the majority of the per-run votes and is announced with a one-cycle valid pulse. There are two networks with separate drive lines, and only the selected one is ever driven.

Top module: `puf_chal_seq`

## Requirements
- R1: The challenge is driven on the selected line one bit per bit-delay period in index order: bit 0 first, bit 31 last.
- R2: Each challenge bit stays on the line for exactly T clock cycles, where T is the effective bit delay captured at start; a computed delay of 0 is treated as 1.
- R3: `adcStart` pulses for exactly one cycle, in the first cycle after bit 31's T cycles. Bit 31 stays on the line until the conversion completes. A sample is taken only on an `adcDone` that arrives after that pulse; `adcDone` at any other time has no effect on the response.
- R4: The vote bit of a sample is chosen by `bitSel`: 2'b01 selects ADC bit 4, 2'b10 selects bit 6, and 2'b00 or 2'b11 selects bit 5.
- R5: With `varMode` = 0 the bit delay is `fixedDelay` cycles for every challenge.
- R6: With `varMode` = 1 the bit delay is `baseDelay` plus the calibration value. With `calWide` = 1 all 5 bits of `calValue` are used; with `calWide` = 0 only `calValue[3:0]` is used.
- R7: `chanSel` = 0 selects `driveA` and 1 selects `driveB`. The unselected line stays low for the whole request.
- R8: Before every run, both drive lines are low for `dischargeCycles` cycles, with 0 treated as 1. Both lines are also low whenever the block is idle.
- R9: The number of runs is `repeatCnt` with bit 0 forced to 1, so an even count n gives n+1 runs and 0 gives 1 run. `respBit` is 1 exactly when more than half of the runs voted 1.
- R10: `busy` is high from the cycle after an accepted start through the cycle of `respValid`. `respValid` is a one-cycle pulse. `respBit` holds its value until the next result. A `start` while `busy` is high is ignored.
- R11: All setup inputs are captured when a start is accepted; changing them while `busy` is high has no effect on the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run a challenge (accepted when not busy) |
| challenge | input | 32 | Challenge word |
| varMode | input | 1 | 0 fixed delay, 1 base plus calibration |
| fixedDelay | input | 16 | Bit delay in cycles for fixed mode |
| baseDelay | input | 16 | Base bit delay in cycles for variable mode |
| calValue | input | 5 | Per-device calibration value |
| calWide | input | 1 | 1 uses 5 calibration bits, 0 uses 4 |
| bitSel | input | 2 | Vote bit selector of the ADC sample |
| chanSel | input | 1 | Network select: 0 line A, 1 line B |
| repeatCnt | input | 7 | Requested run count (made odd) |
| dischargeCycles | input | 16 | Low time before each run, in cycles |
| driveA | output | 1 | Drive line of network A |
| driveB | output | 1 | Drive line of network B |
| adcStart | output | 1 | One-cycle conversion request |
| adcDone | input | 1 | Conversion complete strobe |
| adcData | input | 12 | ADC sample, valid with adcDone |
| busy | output | 1 | Request in progress |
| respValid | output | 1 | One-cycle result pulse |
| respBit | output | 1 | Majority response bit |

## Verification
Two events can arrive in the same cycle: the valid pulse that ends one request and a new start request. The bench raises `start` in exactly the `respValid` cycle and holds it. The bench then checks that the block goes idle for one cycle with the old result still held, and that the new request begins on the following edge. A second collision is a spurious `adcDone` carrying an inverted sample. This pulse, together with a `start` and changed setup inputs, is driven in the middle of a run. The bench judges it by the unchanged drive pattern and by the majority result.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISCH,
    ST_BITS,
    ST_ADC_REQ,
    ST_ADC_WAIT,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic loadDis;
    logic loadChal;
    logic shiftBit;
    logic tally;
    logic latchResp;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic timerZero;
    logic lastBit;
    logic lastRun;
  } seqStatus_t;

  localparam logic [1:0] SEL_LOW  = 2'b01;
  localparam logic [1:0] SEL_HIGH = 2'b10;

endpackage

// File: rtl/puf_seq_ctrl.sv
module puf_seq_ctrl
  import puf_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       adcDone,
  input  seqStatus_t status,
  output seqStrobe_t strb,
  output logic       driveEn,
  output logic       adcStart,
  output logic       busy,
  output logic       respValid
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadCfg = 1'b1;
          stateNext    = ST_DISCH;
        end
      end
      ST_DISCH: begin
        if (status.timerZero) begin
          strb.loadChal = 1'b1;
          stateNext     = ST_BITS;
        end
      end
      ST_BITS: begin
        if (status.timerZero) begin
          if (status.lastBit) stateNext     = ST_ADC_REQ;
          else                strb.shiftBit = 1'b1;
        end
      end
      ST_ADC_REQ: stateNext = ST_ADC_WAIT;
      ST_ADC_WAIT: begin
        if (adcDone) begin
          strb.tally = 1'b1;
          if (status.lastRun) begin
            strb.latchResp = 1'b1;
            stateNext      = ST_DONE;
          end else begin
            strb.loadDis = 1'b1;
            stateNext    = ST_DISCH;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign adcStart  = (state == ST_ADC_REQ);
  assign respValid = (state == ST_DONE);
  assign driveEn   = (state == ST_BITS) || (state == ST_ADC_REQ) || (state == ST_ADC_WAIT);

  p_adcstart_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adcStart |=> !adcStart);

  p_valid_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(respValid) |-> $past(adcDone));

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |=> !respValid);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

// File: rtl/puf_seq_dp.sv
module puf_seq_dp
  import puf_seq_pkg::*;
#(
  parameter int CHAL_W   = 32,
  parameter int ADC_W    = 12,
  parameter int DLY_W    = 16,
  parameter int CAL_W    = 5,
  parameter int REP_W    = 7,
  parameter int DIS_W    = 16,
  parameter int RESP_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strb,
  output seqStatus_t        status,
  input  logic [CHAL_W-1:0] challenge,
  input  logic              varMode,
  input  logic [DLY_W-1:0]  fixedDelay,
  input  logic [DLY_W-1:0]  baseDelay,
  input  logic [CAL_W-1:0]  calValue,
  input  logic              calWide,
  input  logic [1:0]        bitSel,
  input  logic              chanSel,
  input  logic [REP_W-1:0]  repeatCnt,
  input  logic [DIS_W-1:0]  dischargeCycles,
  input  logic [ADC_W-1:0]  adcData,
  output logic              curBit,
  output logic              chanReg,
  output logic              respBit
);

  localparam int SUM_W    = DLY_W + 1;
  localparam int TMR_W    = (SUM_W > DIS_W) ? SUM_W : DIS_W;
  localparam int IDX_W    = $clog2(CHAL_W);
  localparam int LOW_POS  = RESP_POS - 1;
  localparam int HIGH_POS = RESP_POS + 1;

  logic [CHAL_W-1:0] chalReg, shiftReg;
  logic [IDX_W-1:0]  bitIdx;
  logic [TMR_W-1:0]  timer;
  logic [SUM_W-1:0]  dlyReg;
  logic [DIS_W-1:0]  disReg;
  logic [1:0]        selReg;
  logic [REP_W-1:0]  repsReg, runCnt, onesCnt;
  logic              respReg;

  logic [SUM_W-1:0]  calUsed, dlyRaw, dlyEff;
  logic [DIS_W-1:0]  disEffIn;
  logic [REP_W-1:0]  onesNext;
  logic              selBit;

  always_comb begin
    calUsed  = calWide ? SUM_W'(calValue) : SUM_W'(calValue[CAL_W-2:0]);
    dlyRaw   = varMode ? (SUM_W'(baseDelay) + calUsed) : SUM_W'(fixedDelay);
    dlyEff   = (dlyRaw == '0) ? SUM_W'(1) : dlyRaw;
    disEffIn = (dischargeCycles == '0) ? DIS_W'(1) : dischargeCycles;
    unique case (selReg)
      SEL_LOW:  selBit = adcData[LOW_POS];
      SEL_HIGH: selBit = adcData[HIGH_POS];
      default:  selBit = adcData[RESP_POS];
    endcase
    onesNext = onesCnt + REP_W'(selBit);
  end

  // captured setup
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chalReg <= '0;
      dlyReg  <= SUM_W'(1);
      disReg  <= DIS_W'(1);
      selReg  <= '0;
      chanReg <= 1'b0;
      repsReg <= REP_W'(1);
    end else if (strb.loadCfg) begin
      chalReg <= challenge;
      dlyReg  <= dlyEff;
      disReg  <= disEffIn;
      selReg  <= bitSel;
      chanReg <= chanSel;
      repsReg <= repeatCnt | REP_W'(1);
    end
  end

  // shared interval timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            timer <= '0;
    else if (strb.loadCfg)                 timer <= TMR_W'(disEffIn) - TMR_W'(1);
    else if (strb.loadDis)                 timer <= TMR_W'(disReg) - TMR_W'(1);
    else if (strb.loadChal || strb.shiftBit) timer <= TMR_W'(dlyReg) - TMR_W'(1);
    else if (timer != '0)                  timer <= timer - TMR_W'(1);
  end

  // challenge serializer, LSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      bitIdx   <= '0;
    end else if (strb.loadChal) begin
      shiftReg <= chalReg;
      bitIdx   <= '0;
    end else if (strb.shiftBit) begin
      shiftReg <= shiftReg >> 1;
      bitIdx   <= bitIdx + IDX_W'(1);
    end
  end

  // vote accumulation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt  <= '0;
      onesCnt <= '0;
      respReg <= 1'b0;
    end else begin
      if (strb.loadCfg) begin
        runCnt  <= '0;
        onesCnt <= '0;
      end else if (strb.tally) begin
        runCnt  <= runCnt + REP_W'(1);
        onesCnt <= onesNext;
      end
      if (strb.latchResp)
        respReg <= ({onesNext, 1'b0} > {1'b0, repsReg});
    end
  end

  assign curBit           = shiftReg[0];
  assign respBit          = respReg;
  assign status.timerZero = (timer == '0);
  assign status.lastBit   = (bitIdx == IDX_W'(CHAL_W - 1));
  assign status.lastRun   = (runCnt == repsReg - REP_W'(1));

  p_vote_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    onesCnt <= runCnt);

  p_shift_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shiftBit |=> (bitIdx == $past(bitIdx) + IDX_W'(1)));

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadCfg |=> ($stable(dlyReg) && $stable(chanReg) && $stable(chalReg)));

  p_delay_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dlyReg != '0);

endmodule

// File: rtl/puf_chal_seq.sv
module puf_chal_seq
  import puf_seq_pkg::*;
#(
  parameter int CHAL_W   = 32,
  parameter int ADC_W    = 12,
  parameter int DLY_W    = 16,
  parameter int CAL_W    = 5,
  parameter int REP_W    = 7,
  parameter int DIS_W    = 16,
  parameter int RESP_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAL_W-1:0] challenge,
  input  logic              varMode,
  input  logic [DLY_W-1:0]  fixedDelay,
  input  logic [DLY_W-1:0]  baseDelay,
  input  logic [CAL_W-1:0]  calValue,
  input  logic              calWide,
  input  logic [1:0]        bitSel,
  input  logic              chanSel,
  input  logic [REP_W-1:0]  repeatCnt,
  input  logic [DIS_W-1:0]  dischargeCycles,
  output logic              driveA,
  output logic              driveB,
  output logic              adcStart,
  input  logic              adcDone,
  input  logic [ADC_W-1:0]  adcData,
  output logic              busy,
  output logic              respValid,
  output logic              respBit
);

  seqStrobe_t strb;
  seqStatus_t status;
  logic       driveEn, curBit, chanReg;

  puf_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .adcDone(adcDone),
    .status(status), .strb(strb), .driveEn(driveEn), .adcStart(adcStart),
    .busy(busy), .respValid(respValid)
  );

  puf_seq_dp #(
    .CHAL_W(CHAL_W), .ADC_W(ADC_W), .DLY_W(DLY_W), .CAL_W(CAL_W),
    .REP_W(REP_W), .DIS_W(DIS_W), .RESP_POS(RESP_POS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .status(status),
    .challenge(challenge), .varMode(varMode), .fixedDelay(fixedDelay),
    .baseDelay(baseDelay), .calValue(calValue), .calWide(calWide),
    .bitSel(bitSel), .chanSel(chanSel), .repeatCnt(repeatCnt),
    .dischargeCycles(dischargeCycles), .adcData(adcData),
    .curBit(curBit), .chanReg(chanReg), .respBit(respBit)
  );

  assign driveA = driveEn && !chanReg && curBit;
  assign driveB = driveEn &&  chanReg && curBit;

  p_unsel_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(driveA && driveB));

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!driveA && !driveB));

endmodule

// File: tb/puf_chal_seq_tb.sv
`timescale 1ns/1ps
module puf_chal_seq_tb;

  typedef struct packed {
    logic [31:0] chal;
    logic        varMode;
    logic [15:0] fixedDly;
    logic [15:0] baseDly;
    logic [4:0]  cal;
    logic        calWide;
    logic [1:0]  bitSel;
    logic        chan;
    logic [6:0]  reps;
    logic [15:0] dis;
    logic [7:0]  voteMask;
    logic [3:0]  lat;
    logic        spur;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'hA5C3_0F96, 1'b0, 16'd2, 16'd0, 5'd0,  1'b0, 2'b00, 1'b0, 7'd1, 16'd3, 8'b0000_0001, 4'd2, 1'b0},
    '{32'h8000_0001, 1'b0, 16'd3, 16'd0, 5'd0,  1'b0, 2'b01, 1'b1, 7'd3, 16'd2, 8'b0000_0101, 4'd1, 1'b1},
    '{32'h6B1E_D24C, 1'b1, 16'd9, 16'd4, 5'd19, 1'b0, 2'b10, 1'b0, 7'd3, 16'd1, 8'b0000_0001, 4'd3, 1'b0},
    '{32'hC3C3_3C3C, 1'b1, 16'd9, 16'd1, 5'd19, 1'b1, 2'b11, 1'b1, 7'd2, 16'd0, 8'b0000_0110, 4'd2, 1'b1},
    '{32'h0000_FFFF, 1'b0, 16'd0, 16'd0, 5'd0,  1'b0, 2'b00, 1'b1, 7'd0, 16'd4, 8'b0000_0000, 4'd0, 1'b0},
    '{32'h1234_5678, 1'b0, 16'd1, 16'd0, 5'd0,  1'b0, 2'b01, 1'b0, 7'd5, 16'd2, 8'b0000_1011, 4'd1, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, varMode = 1'b0, calWide = 1'b0, chanSel = 1'b0, adcDone = 1'b0;
  logic [31:0] challenge = '0;
  logic [15:0] fixedDelay = '0, baseDelay = '0, dischargeCycles = '0;
  logic [4:0]  calValue = '0;
  logic [1:0]  bitSel = '0;
  logic [6:0]  repeatCnt = '0;
  logic [11:0] adcData = '0;
  logic        driveA, driveB, adcStart, busy, respValid, respBit;

  int nChk = 0, nFail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  puf_chal_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
    .varMode(varMode), .fixedDelay(fixedDelay), .baseDelay(baseDelay),
    .calValue(calValue), .calWide(calWide), .bitSel(bitSel), .chanSel(chanSel),
    .repeatCnt(repeatCnt), .dischargeCycles(dischargeCycles),
    .driveA(driveA), .driveB(driveB), .adcStart(adcStart), .adcDone(adcDone),
    .adcData(adcData), .busy(busy), .respValid(respValid), .respBit(respBit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] sampleFor(input logic [1:0] sel, input logic v);
    int pos;
    pos = (sel == 2'b01) ? 4 : (sel == 2'b10) ? 6 : 5;
    return v ? (12'h001 << pos) : ~(12'h001 << pos);
  endfunction

  // one full request; returns at the first idle cycle after respValid
  task automatic run_vec(input vec_t v, input bit overlap);
    int T, D, R, ones, errDis, errBit, errOther, errAdc;
    logic exp;
    string bitTag;
    T = v.varMode ? (v.baseDly + (v.calWide ? v.cal : {1'b0, v.cal[3:0]})) : v.fixedDly;
    if (T == 0) T = 1;
    D = (v.dis == 0) ? 1 : v.dis;
    R = v.reps | 1;
    ones = 0;
    for (int k = 0; k < R; k++) ones += v.voteMask[k];
    exp = (2 * ones > R);
    errDis = 0; errBit = 0; errOther = 0; errAdc = 0;
    challenge = v.chal; varMode = v.varMode; fixedDelay = v.fixedDly;
    baseDelay = v.baseDly; calValue = v.cal; calWide = v.calWide;
    bitSel = v.bitSel; chanSel = v.chan; repeatCnt = v.reps; dischargeCycles = v.dis;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    for (int run = 0; run < R; run++) begin
      for (int c = 0; c < D; c++) begin
        if (driveA || driveB) errDis++;
        @(negedge clk);
      end
      for (int i = 0; i < 32; i++) begin
        for (int t = 0; t < T; t++) begin
          start   = v.spur && i == 3 && t == 0;
          adcDone = v.spur && i == 5 && t == 0;
          adcData = sampleFor(v.bitSel, !v.voteMask[run]);
          if (start) begin
            challenge = ~v.chal; chanSel = ~v.chan; fixedDelay = 16'd5; baseDelay = 16'd7;
          end
          if ((v.chan ? driveB : driveA) != v.chal[i]) errBit++;
          if ((v.chan ? driveA : driveB) != 1'b0) errOther++;
          if (adcStart) errAdc++;
          @(negedge clk);
        end
      end
      start = 1'b0; adcDone = 1'b0;
      if (adcStart != 1'b1) errAdc++;
      if ((v.chan ? driveB : driveA) != v.chal[31]) errBit++;
      @(negedge clk);
      for (int l = 0; l < v.lat; l++) begin
        if (adcStart) errAdc++;
        if ((v.chan ? driveB : driveA) != v.chal[31]) errBit++;
        @(negedge clk);
      end
      adcDone = 1'b1;
      adcData = sampleFor(v.bitSel, v.voteMask[run]);
      @(negedge clk);
      adcDone = 1'b0;
      adcData = 12'h000;
    end
    bitTag = {"R1 R2 ", v.varMode ? "R6" : "R5", v.spur ? " R11" : ""};
    chk(errBit == 0, {bitTag, " bit order and hold"}, errBit, 0);
    chk(errOther == 0, "R7 unselected line low", errOther, 0);
    chk(errDis == 0, "R8 discharge low", errDis, 0);
    chk(errAdc == 0, "R3 adcStart single pulse after last bit", errAdc, 0);
    if (overlap) start = 1'b1;
    chk(respValid == 1'b1, "R10 respValid", respValid, 1);
    chk(respBit == exp, {"R3 R4 R9 majority", v.spur ? " R11" : ""}, respBit, exp);
    @(negedge clk);
    chk(respValid == 1'b0 && busy == 1'b0, "R10 pulse ends, idle", {busy, respValid}, 0);
    chk(respBit == exp, "R10 respBit held", respBit, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({driveA, driveB, adcStart, busy, respValid, respBit} == 6'b0, "R8 R10 reset state",
        {driveA, driveB, adcStart, busy, respValid, respBit}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({driveA, driveB, adcStart, busy, respValid} == 5'b0, "R8 idle after reset",
        {driveA, driveB, adcStart, busy, respValid}, 0);
    for (int n = 0; n < NVEC; n++) run_vec(VECS[n], 1'b0);
    // start raised in the respValid cycle is dropped, then accepted next edge
    run_vec(VECS[0], 1'b1);
    run_vec(VECS[5], 1'b0);
    // idle line stays low after the last request
    repeat (4) @(negedge clk);
    chk({driveA, driveB, busy} == 3'b0, "R8 idle low", {driveA, driveB, busy}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule